// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a chain of identical 4-bit synchronous up-counting stages that share one clock and form a single wider binary counter. Each stage can be cleared at any time by an active-low clear that needs no clock edge. It can also be preset from a data word on a clock edge, and it counts only when two enables are both high. One enable goes to every stage. The other is the carry into the lowest stage. Each higher stage takes its second enable from the terminal-count flag of the stage below it.

The terminal-count flag of a stage is combinational. It is high when the stage holds all ones and its carry enable is high. Because of this, a carry travels up the whole chain in the cycle before the edge that uses it, and every stage changes on the same edge. The flag from the top stage leaves the block as the carry output, so the block can drive a further chain. The number of stages and the stage width are parameters.

Top module: `cnt_chain`

## Requirements
- R1: While `clrN` is low, `count` is zero and `carryOut` is low, with no clock edge needed. The change takes effect as soon as `clrN` falls.
- R2: Clear has priority over everything. While `clrN` stays low, rising edges leave `count` at zero whatever `ldN`, `preset` and the enables are.
- R3: With `clrN` high and `ldN` low, the next rising edge copies `preset` into `count` whatever the enables are. Bit i of `preset` goes to bit i of `count`.
- R4: With `clrN` and `ldN` high and both `enableAll` and `enableCarry` high, each rising edge adds one to `count`. The all-ones value wraps to zero.
- R5: With `clrN` and `ldN` high and either enable low, `count` does not change on the rising edge.
- R6: `carryOut` is high exactly when `count` is all ones and `enableCarry` is high. It follows `enableCarry` with no clock edge.
- R7: The chain of `NUM_STAGES` stages behaves as one binary counter `STAGE_W*NUM_STAGES` bits wide. Stage k (bits k*STAGE_W and up) advances only when every lower stage is all ones. A load or a clear in the middle of a count sequence does not disturb this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clrN | input | 1 | Asynchronous clear, active low |
| ldN | input | 1 | Synchronous parallel load, active low |
| preset | input | STAGE_W*NUM_STAGES | Value taken in on a load |
| enableAll | input | 1 | Count enable shared by all stages |
| enableCarry | input | 1 | Carry enable into the lowest stage; also gates `carryOut` |
| count | output | STAGE_W*NUM_STAGES | Current count, lowest stage in the low bits |
| carryOut | output | 1 | Terminal-count flag of the top stage |

## Verification
A wrong stage register shows up at `count` on the first rising edge after the fault. A lost or extra carry between stages shows up as a wrong upper nibble on the edge that should have rolled the lower stages over. A fault in the terminal-count gating shows up on `carryOut` at once, in the same cycle, because that output does not wait for a clock. The bench compares every cycle against a wide arithmetic counter. It sweeps the full count range, then runs a long mix of loads, holds and counts. It also makes checks between clock edges to cover the asynchronous clear and the combinational carry.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Strobes from a stage's control to its datapath
  typedef struct packed {
    logic doLoad;
    logic doInc;
  } cntStrobe_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic       ldN,
  input  logic       enPar,
  input  logic       enTrk,
  output cntStrobe_t strobe
);
  // Load overrides counting; counting needs both enables
  always_comb begin
    strobe.doLoad = !ldN;
    strobe.doInc  = ldN && enPar && enTrk;
  end
endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] presetVal,
  input  logic             enTrk,
  output logic [WIDTH-1:0] q,
  output logic             termCnt
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)              q <= '0;
    else if (strobe.doLoad) q <= presetVal;
    else if (strobe.doInc)  q <= q + 1'b1;
  end

  // Lookahead carry: formed from the stored value and the incoming carry
  assign termCnt = (q == MAX_VAL) && enTrk;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             ldN,
  input  logic [WIDTH-1:0] presetVal,
  input  logic             enPar,
  input  logic             enTrk,
  output logic [WIDTH-1:0] q,
  output logic             termCnt
);
  cntStrobe_t strobe;

  cnt_ctrl ctrl_i (
    .ldN   (ldN),
    .enPar (enPar),
    .enTrk (enTrk),
    .strobe(strobe)
  );

  cnt_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .clrN     (clrN),
    .strobe   (strobe),
    .presetVal(presetVal),
    .enTrk    (enTrk),
    .q        (q),
    .termCnt  (termCnt)
  );
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 3,
  localparam int TOTAL_W   = STAGE_W * NUM_STAGES
) (
  input  logic               clk,
  input  logic               clrN,
  input  logic               ldN,
  input  logic [TOTAL_W-1:0] preset,
  input  logic               enableAll,
  input  logic               enableCarry,
  output logic [TOTAL_W-1:0] count,
  output logic               carryOut
);
  logic [NUM_STAGES:0] carryLink;

  assign carryLink[0] = enableCarry;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    cnt_stage #(.WIDTH(STAGE_W)) stage_i (
      .clk      (clk),
      .clrN     (clrN),
      .ldN      (ldN),
      .presetVal(preset[k*STAGE_W +: STAGE_W]),
      .enPar    (enableAll),
      .enTrk    (carryLink[k]),
      .q        (count[k*STAGE_W +: STAGE_W]),
      .termCnt  (carryLink[k+1])
    );
  end

  assign carryOut = carryLink[NUM_STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int TOTAL_W = 12
) (
  input logic               clk,
  input logic               clrN,
  input logic               ldN,
  input logic [TOTAL_W-1:0] preset,
  input logic               enableAll,
  input logic               enableCarry,
  input logic [TOTAL_W-1:0] count,
  input logic               carryOut
);
  // R1 R2
  clear_zero_chk: assert property (@(posedge clk)
    !clrN |-> (count == '0 && !carryOut));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!clrN)
    !ldN |=> count == $past(preset));

  // R4 R7
  count_step_chk: assert property (@(posedge clk) disable iff (!clrN)
    (ldN && enableAll && enableCarry) |=> count == TOTAL_W'($past(count) + 1'b1));

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (!clrN)
    (ldN && !(enableAll && enableCarry)) |=> $stable(count));

  // R6
  carry_flag_chk: assert property (@(posedge clk) disable iff (!clrN)
    carryOut == ((&count) && enableCarry));
endmodule

bind cnt_chain cnt_chain_chk #(.TOTAL_W(TOTAL_W)) chk_i (
  .clk        (clk),
  .clrN       (clrN),
  .ldN        (ldN),
  .preset     (preset),
  .enableAll  (enableAll),
  .enableCarry(enableCarry),
  .count      (count),
  .carryOut   (carryOut)
);

// File: tb/cnt_chain_tb_top.sv
`timescale 1ns/1ps
module cnt_chain_tb_top;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int TW = SW * NS;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          clrN, ldN, enableAll, enableCarry;
  logic [TW-1:0] preset, count;
  logic          carryOut;
  logic [TW-1:0] expCount = '0;
  int            nChecks = 0;
  int            nFail = 0;
  bit            done = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;

  cnt_chain #(.STAGE_W(SW), .NUM_STAGES(NS)) dut_i (
    .clk(clk), .clrN(clrN), .ldN(ldN), .preset(preset),
    .enableAll(enableAll), .enableCarry(enableCarry),
    .count(count), .carryOut(carryOut)
  );

  task automatic check(string req, logic [TW-1:0] expC, logic expT);
    nChecks++;
    if (count !== expC || carryOut !== expT) begin
      nFail++;
      $display("FAIL %s: count=%h carryOut=%b expected count=%h carryOut=%b",
               req, count, carryOut, expC, expT);
    end
  endtask

  // One clock: update the reference from the inputs seen at the edge, then check
  task automatic tick(string req);
    @(posedge clk);
    if (!clrN)                         expCount = '0;
    else if (!ldN)                     expCount = preset;
    else if (enableAll && enableCarry) expCount = expCount + 1'b1;
    #1;
    check(req, expCount, (&expCount) && enableCarry);
  endtask

  initial begin
    clrN = 1'b1; ldN = 1'b0; enableAll = 1'b1; enableCarry = 1'b1; preset = '1;
    #1 clrN = 1'b0;
    #1 check("R1", '0, 1'b0);
    // clear beats load and enables
    repeat (3) tick("R2");

    clrN = 1'b1; ldN = 1'b1; preset = '0;
    // full sweep with wrap (R4, R6 each cycle)
    for (int i = 0; i < (1 << TW) + 4; i++) tick("R7");

    // explicit wrap from all ones
    ldN = 1'b0; preset = '1; tick("R3");
    ldN = 1'b1; tick("R4");

    // combinational carry
    ldN = 1'b0; preset = '1; enableAll = 1'b0; tick("R3");
    ldN = 1'b1; enableCarry = 1'b0;
    #0.5 check("R6", '1, 1'b0);
    enableCarry = 1'b1;
    #0.5 check("R6", '1, 1'b1);
    enableCarry = 1'b0;
    tick("R5");

    // lower stages at max, top not: no carry out, then a two-stage rollover
    ldN = 1'b0; preset = 12'h0FF; enableAll = 1'b1; enableCarry = 1'b1; tick("R3");
    ldN = 1'b1; tick("R7");
    check("R7", 12'h100, 1'b0);

    // mixed loads, holds and counts
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ldN         = (lfsr[3:0] != 4'd0);
      enableAll   = (lfsr[5:4] != 2'd0);
      enableCarry = (lfsr[7:6] != 2'd0);
      preset      = lfsr[15:4];
      if (lfsr[9]) preset[7:0] = 8'hFF;
      tick("R5");
    end

    // clear in the middle of counting, between edges
    ldN = 1'b1; enableAll = 1'b1; enableCarry = 1'b1;
    tick("R4");
    clrN = 1'b0;
    #1 check("R1", '0, 1'b0);
    ldN = 1'b0; preset = 12'h5A5;
    tick("R2");
    clrN = 1'b1; ldN = 1'b1;
    tick("R7");
    check("R7", 12'h001, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    done = 1'b1;
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule